// File: doc/BRIEF.md
# Control Loop Timing Monitor

This block paces a sampled control loop and checks how each loop iteration uses its time. A free-running period counter issues a one-cycle sample trigger at a fixed, programmable interval. The interval never depends on when the previous iteration finished. Downstream processing logic answers each trigger with a one-cycle completion pulse. The monitor measures how long the work took, how much of the period was left over, and what fraction of the period was used. When work is still open at the next trigger, it raises a sticky overrun flag.

A second input watches an output strobe, such as the frame-sync of a converter that the loop feeds. The block measures the interval between strobes, the change in that interval from one strobe to the next, and the extremes of both interval and compute time. A trigger window that passes without any strobe means the output side dropped a sample. The block counts that event and flags it. Software reads all statistics through a small address-indexed readout and clears the flags, counters and extremes with a clear pulse.

The period value is taken at each trigger. Values below `FRAC_W + 4` clock cycles are raised to that minimum, so that the load divider always finishes inside one period.

Top module: `loop_timing_mon`

## Requirements
- R1: With `enable_i` high, `trig_o` is high in the first enabled cycle and then exactly once every P cycles. P is the value of `period_i` taken in each trigger cycle and applies to the interval that follows that trigger.
- R2: A done pulse in the k-th cycle after a trigger (k >= 1, the trigger cycle being k = 0) closes the open cycle. Address 0 then reads k.
- R3: For each accepted done, address 1 reads P minus the compute time.
- R4: Address 2 reads floor(compute * 256 / P) for the last accepted cycle. The value is valid within `FRAC_W + 2` cycles after the trigger that follows that done.
- R5: A trigger while the previous cycle is still open counts a missed deadline. A done in the trigger cycle itself counts as late. Each miss adds one to the counter at address 9 and sets `overrun_o`, which stays high until a clear.
- R6: A done with no open cycle counts one at address 10 and leaves addresses 0 and 1 unchanged. This covers a second done in the same window.
- R7: Address 3 reads the number of cycles between the two latest rising edges of `strobe_i`. Address 4 reads the absolute difference between the two latest such intervals.
- R8: Addresses 5 and 6 hold the smallest and largest strobe interval. Addresses 7 and 8 hold the smallest and largest accepted compute time.
- R9: A trigger that ends a window with no strobe rising edge adds one to the counter at address 11 and sets `drop_o`, which is sticky. The first window after enable is checked. A rising edge in the trigger cycle counts for the window that is ending.
- R10: `clr_i` clears `overrun_o`, `drop_o` and the counters at addresses 9 to 11. It sets addresses 5 and 7 to all ones and addresses 6 and 8 to zero.
- R11: After reset, `trig_o`, `overrun_o` and `drop_o` are low and addresses 0 to 4 and 6, 8 to 11 read zero. Addresses 5 and 7 read all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Runs the period counter |
| period_i | input | CNT_W | Sample period in clock cycles |
| done_i | input | 1 | Work-complete pulse from processing logic |
| strobe_i | input | 1 | Monitored output strobe |
| clr_i | input | 1 | Clears flags, event counters and extremes |
| rd_addr_i | input | 4 | Statistics readout address |
| trig_o | output | 1 | Sample trigger pulse |
| overrun_o | output | 1 | Sticky missed-deadline flag |
| drop_o | output | 1 | Sticky dropped-sample flag |
| rd_data_o | output | CNT_W | Statistics readout data, zero-extended |

## Verification
On every cycle the embedded assertions check several things. Triggers are never back to back. An accepted done always lies inside its period, and its compute time and slack add up to that period. Every finished load quotient lies within one unit of the exact ratio. The miss and drop flags stay set until a clear, and the spurious counter moves by exactly one per stray done. The exact spacing of triggers after a period change, the strobe interval and jitter values, the running extremes, and the window that a drop or miss is charged to depend on a stimulus history. Only the bench scenarios can show those, by comparing the readout against a model kept in the bench.

// File: rtl/ltm_pkg.sv
`timescale 1ns/1ps
package ltm_pkg;
  typedef enum logic [3:0] {
    RA_COMP  = 4'd0,
    RA_SLACK = 4'd1,
    RA_LOAD  = 4'd2,
    RA_PER   = 4'd3,
    RA_JIT   = 4'd4,
    RA_PMIN  = 4'd5,
    RA_PMAX  = 4'd6,
    RA_CMIN  = 4'd7,
    RA_CMAX  = 4'd8,
    RA_MISS  = 4'd9,
    RA_SPUR  = 4'd10,
    RA_DROP  = 4'd11
  } reg_addr_e;
endpackage

// File: rtl/ltm_timer.sv
`timescale 1ns/1ps
module ltm_timer #(
  parameter int CNT_W   = 16,
  parameter int MIN_PER = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             trig_o,
  output logic [CNT_W-1:0] per_o
);
  logic [CNT_W-1:0] tmr_q, per_q, per_eff, cur_per;

  assign per_eff = (period_i < CNT_W'(MIN_PER)) ? CNT_W'(MIN_PER) : period_i;
  assign trig_o  = enable_i && (tmr_q == '0);
  assign cur_per = trig_o ? per_eff : per_q;
  assign per_o   = per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      per_q <= '0;
    end else begin
      if (!enable_i)                        tmr_q <= '0;
      else if (tmr_q == cur_per - 1'b1)     tmr_q <= '0;
      else                                  tmr_q <= tmr_q + 1'b1;
      if (trig_o) per_q <= per_eff;
    end
  end

  // R1
  trig_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  // R1
  per_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> per_q >= CNT_W'(MIN_PER));
endmodule

// File: rtl/ltm_cycle.sv
`timescale 1ns/1ps
module ltm_cycle #(
  parameter int CNT_W = 16,
  parameter int EVT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             done_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] comp_o,
  output logic [CNT_W-1:0] slack_o,
  output logic [CNT_W-1:0] cmin_o,
  output logic [CNT_W-1:0] cmax_o,
  output logic [EVT_W-1:0] miss_o,
  output logic [EVT_W-1:0] spur_o,
  output logic             overrun_o,
  output logic             div_start_o,
  output logic [CNT_W-1:0] div_num_o,
  output logic [CNT_W-1:0] div_den_o
);
  logic             pend_q, hvld_q, ovr_q;
  logic [CNT_W-1:0] ela_q, comp_q, slack_q, cmin_q, cmax_q, hcomp_q, hper_q;
  logic [EVT_W-1:0] miss_q, spur_q;
  logic             acc, miss_ev, spur_ev;

  assign miss_ev = trig_i && pend_q;           // late or absent done
  assign acc     = done_i && pend_q && !trig_i;
  assign spur_ev = done_i && !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      hvld_q  <= 1'b0;
      ovr_q   <= 1'b0;
      ela_q   <= '0;
      comp_q  <= '0;
      slack_q <= '0;
      hcomp_q <= '0;
      hper_q  <= '0;
      cmin_q  <= '1;
      cmax_q  <= '0;
      miss_q  <= '0;
      spur_q  <= '0;
    end else begin
      if (trig_i) begin
        pend_q <= 1'b1;
        ela_q  <= CNT_W'(1);
      end else if (acc) begin
        pend_q <= 1'b0;
      end else if (pend_q && ela_q != '1) begin
        ela_q <= ela_q + 1'b1;
      end

      if (acc) begin
        comp_q  <= ela_q;
        slack_q <= per_i - ela_q;
        hcomp_q <= ela_q;
        hper_q  <= per_i;
      end
      // hold the finished sample until the next trigger launches the divide
      if (acc)         hvld_q <= 1'b1;
      else if (trig_i) hvld_q <= 1'b0;

      if (clr_i) begin
        ovr_q  <= 1'b0;
        miss_q <= '0;
        spur_q <= '0;
        cmin_q <= '1;
        cmax_q <= '0;
      end else begin
        if (miss_ev) begin
          ovr_q <= 1'b1;
          if (miss_q != '1) miss_q <= miss_q + 1'b1;
        end
        if (spur_ev && spur_q != '1) spur_q <= spur_q + 1'b1;
        if (acc) begin
          if (ela_q < cmin_q) cmin_q <= ela_q;
          if (ela_q > cmax_q) cmax_q <= ela_q;
        end
      end
    end
  end

  assign comp_o      = comp_q;
  assign slack_o     = slack_q;
  assign cmin_o      = cmin_q;
  assign cmax_o      = cmax_q;
  assign miss_o      = miss_q;
  assign spur_o      = spur_q;
  assign overrun_o   = ovr_q;
  assign div_start_o = trig_i && hvld_q;
  assign div_num_o   = hcomp_q;
  assign div_den_o   = hper_q;

  // R2
  comp_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> ela_q < per_i);
  // R3
  slack_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (comp_q + slack_q) == $past(per_i));
  // R5
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q && !clr_i |=> ovr_q);
  // R6
  spur_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spur_ev && !clr_i && spur_q != '1 |=> spur_q == $past(spur_q) + EVT_W'(1));
endmodule

// File: rtl/ltm_div.sv
`timescale 1ns/1ps
module ltm_div #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  num_i,
  input  logic [CNT_W-1:0]  den_i,
  output logic [FRAC_W-1:0] q_o
);
  localparam int STEP_W = $clog2(FRAC_W + 1);
  localparam int PW     = CNT_W + FRAC_W + 1;

  logic              busy_q, fin_q, ge;
  logic [CNT_W-1:0]  rem_q, num_q, den_q;
  logic [CNT_W:0]    rem2;
  logic [FRAC_W-1:0] acc_q, q_q;
  logic [STEP_W-1:0] step_q;

  assign rem2 = {rem_q, 1'b0};
  assign ge   = rem2 >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      rem_q  <= '0;
      num_q  <= '0;
      den_q  <= '0;
      acc_q  <= '0;
      q_q    <= '0;
      step_q <= '0;
    end else begin
      fin_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        rem_q  <= num_i;
        num_q  <= num_i;
        den_q  <= den_i;
        acc_q  <= '0;
        step_q <= '0;
      end else if (busy_q) begin
        rem_q <= ge ? CNT_W'(rem2 - {1'b0, den_q}) : CNT_W'(rem2);
        acc_q <= {acc_q[FRAC_W-2:0], ge};
        if (step_q == STEP_W'(FRAC_W - 1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
          q_q    <= {acc_q[FRAC_W-2:0], ge};
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign q_o = q_q;

  logic [PW-1:0] scaled, lo_prod, hi_prod;
  assign scaled  = PW'(num_q) << FRAC_W;
  assign lo_prod = PW'(q_q) * PW'(den_q);
  assign hi_prod = (PW'(q_q) + PW'(1)) * PW'(den_q);

  // R4
  quot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |-> (lo_prod <= scaled) && (hi_prod > scaled));
  // R4
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/ltm_strobe.sv
`timescale 1ns/1ps
module ltm_strobe #(
  parameter int CNT_W = 16,
  parameter int EVT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             trig_i,
  input  logic             strobe_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] jit_o,
  output logic [CNT_W-1:0] pmin_o,
  output logic [CNT_W-1:0] pmax_o,
  output logic [EVT_W-1:0] drop_cnt_o,
  output logic             drop_o
);
  logic             str_d, str_ev, seen_q, pmv_q, arm_q, hit_q, drp_q, drop_ev, meas;
  logic [CNT_W-1:0] scnt_q, pm_q, jit_q, pmin_q, pmax_q;
  logic [EVT_W-1:0] dcnt_q;

  assign str_ev  = strobe_i && !str_d;
  assign meas    = str_ev && seen_q;
  assign drop_ev = trig_i && arm_q && !hit_q && !str_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      str_d  <= 1'b0;
      seen_q <= 1'b0;
      pmv_q  <= 1'b0;
      arm_q  <= 1'b0;
      hit_q  <= 1'b0;
      drp_q  <= 1'b0;
      scnt_q <= '0;
      pm_q   <= '0;
      jit_q  <= '0;
      pmin_q <= '1;
      pmax_q <= '0;
      dcnt_q <= '0;
    end else begin
      str_d <= strobe_i;
      if (str_ev)             scnt_q <= CNT_W'(1);
      else if (scnt_q != '1)  scnt_q <= scnt_q + 1'b1;
      if (str_ev) seen_q <= 1'b1;

      if (meas) begin
        pm_q  <= scnt_q;
        pmv_q <= 1'b1;
        if (pmv_q) jit_q <= (scnt_q > pm_q) ? scnt_q - pm_q : pm_q - scnt_q;
      end

      if (!enable_i) begin
        arm_q <= 1'b0;
        hit_q <= 1'b0;
      end else if (trig_i) begin
        arm_q <= 1'b1;
        hit_q <= 1'b0;
      end else if (str_ev) begin
        hit_q <= 1'b1;
      end

      if (clr_i) begin
        drp_q  <= 1'b0;
        dcnt_q <= '0;
        pmin_q <= '1;
        pmax_q <= '0;
      end else begin
        if (drop_ev) begin
          drp_q <= 1'b1;
          if (dcnt_q != '1) dcnt_q <= dcnt_q + 1'b1;
        end
        if (meas) begin
          if (scnt_q < pmin_q) pmin_q <= scnt_q;
          if (scnt_q > pmax_q) pmax_q <= scnt_q;
        end
      end
    end
  end

  assign per_o      = pm_q;
  assign jit_o      = jit_q;
  assign pmin_o     = pmin_q;
  assign pmax_o     = pmax_q;
  assign drop_cnt_o = dcnt_q;
  assign drop_o     = drp_q;

  // R7
  meas_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmv_q |-> pm_q != '0);
  // R8
  ext_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmax_q != '0) |-> pmin_q <= pmax_q);
  // R9
  drop_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drp_q && !clr_i |=> drp_q);
endmodule

// File: rtl/loop_timing_mon.sv
`timescale 1ns/1ps
module loop_timing_mon
  import ltm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8,
  parameter int EVT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             done_i,
  input  logic             strobe_i,
  input  logic             clr_i,
  input  logic [3:0]       rd_addr_i,
  output logic             trig_o,
  output logic             overrun_o,
  output logic             drop_o,
  output logic [CNT_W-1:0] rd_data_o
);
  localparam int MIN_PER = FRAC_W + 4;

  logic              trig;
  logic [CNT_W-1:0]  per_q, comp, slack, cmin, cmax, div_num, div_den;
  logic [CNT_W-1:0]  sper, sjit, pmin, pmax;
  logic [EVT_W-1:0]  miss, spur, dcnt;
  logic [FRAC_W-1:0] load;
  logic              div_start;

  ltm_timer #(.CNT_W(CNT_W), .MIN_PER(MIN_PER)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .period_i(period_i),
    .trig_o(trig), .per_o(per_q)
  );

  ltm_cycle #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_cycle (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig), .done_i(done_i), .clr_i(clr_i),
    .per_i(per_q), .comp_o(comp), .slack_o(slack), .cmin_o(cmin), .cmax_o(cmax),
    .miss_o(miss), .spur_o(spur), .overrun_o(overrun_o),
    .div_start_o(div_start), .div_num_o(div_num), .div_den_o(div_den)
  );

  ltm_div #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start),
    .num_i(div_num), .den_i(div_den), .q_o(load)
  );

  ltm_strobe #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .trig_i(trig),
    .strobe_i(strobe_i), .clr_i(clr_i), .per_o(sper), .jit_o(sjit),
    .pmin_o(pmin), .pmax_o(pmax), .drop_cnt_o(dcnt), .drop_o(drop_o)
  );

  assign trig_o = trig;

  always_comb begin
    case (rd_addr_i)
      RA_COMP:  rd_data_o = comp;
      RA_SLACK: rd_data_o = slack;
      RA_LOAD:  rd_data_o = CNT_W'(load);
      RA_PER:   rd_data_o = sper;
      RA_JIT:   rd_data_o = sjit;
      RA_PMIN:  rd_data_o = pmin;
      RA_PMAX:  rd_data_o = pmax;
      RA_CMIN:  rd_data_o = cmin;
      RA_CMAX:  rd_data_o = cmax;
      RA_MISS:  rd_data_o = CNT_W'(miss);
      RA_SPUR:  rd_data_o = CNT_W'(spur);
      RA_DROP:  rd_data_o = CNT_W'(dcnt);
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: tb/tb_loop_timing_mon.sv
`timescale 1ns/1ps
module tb_loop_timing_mon;
  localparam int CNT_W  = 16;
  localparam int FRAC_W = 8;
  localparam int EVT_W  = 8;
  localparam int NV     = 9;
  localparam int ONES   = (1 << CNT_W) - 1;
  // {period, done cycle (>=P: none), strobe cycle (>=P: none), extra done}
  localparam int VEC [NV][4] = '{
    '{20,  5,  3, 0},
    '{20, 12,  3, 0},
    '{24,  1,  4, 0},
    '{24, 23,  4, 0},
    '{20, 30,  3, 0},
    '{20,  7, 40, 0},
    '{32,  9,  6, 1},
    '{16,  4,  2, 0},
    '{20,  5,  3, 0}
  };

  logic clk = 1'b0, rst_ni = 1'b0, enable_i = 1'b0, done_i = 1'b0, strobe_i = 1'b0, clr_i = 1'b0;
  logic [CNT_W-1:0] period_i = CNT_W'(20);
  logic [3:0] rd_addr_i = '0;
  logic [CNT_W-1:0] rd_data_o;
  logic trig_o, overrun_o, drop_o;

  int checks = 0, fails = 0;
  int pend = 0, miss = 0, spur = 0, drop = 0, armed = 0, hit = 0;
  int cmin = ONES, cmax = 0, seen = 0, last_st = 0, pm = 0, pmv = 0, jit = 0;
  int pmin = ONES, pmax = 0, t = 0, lv = 0, lexp = 0, last_comp = 0;

  always #2.5 clk = ~clk;

  loop_timing_mon #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .EVT_W(EVT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .period_i(period_i),
    .done_i(done_i), .strobe_i(strobe_i), .clr_i(clr_i), .rd_addr_i(rd_addr_i),
    .trig_o(trig_o), .overrun_o(overrun_o), .drop_o(drop_o), .rd_data_o(rd_data_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    rd_addr_i = 4'(a);
    #0.5;
    v = int'(rd_data_o);
  endtask

  task automatic run_cycle(input int p, input int dk, input int sk, input int x);
    int v;
    #0.5;
    period_i = CNT_W'(p);
    chk("R1 trigger at period start", int'(trig_o), 1);
    if (pend != 0) miss++;
    pend = 1;
    if (armed != 0 && hit == 0) drop++;
    armed = 1;
    hit = 0;
    for (int c = 0; c < p; c++) begin
      done_i   = (c == dk) || (x != 0 && c == dk + 2);
      strobe_i = (c == sk);
      if (c == 1) chk("R1 no trigger mid-period", int'(trig_o), 0);
      if (c == FRAC_W + 2 && lv != 0) begin
        rd(2, v);
        chk("R4 load", v, lexp);
      end
      @(negedge clk);
    end
    done_i = 1'b0;
    strobe_i = 1'b0;
    if (dk < p) begin
      pend = 0;
      if (x != 0) spur++;
      if (dk < cmin) cmin = dk;
      if (dk > cmax) cmax = dk;
      lv = 1;
      lexp = (dk * 256) / p;
      last_comp = dk;
    end else begin
      lv = 0;
    end
    if (sk < p) begin
      hit = 1;
      if (seen != 0) begin
        int npm;
        npm = t + sk - last_st;
        if (pmv != 0) jit = (npm > pm) ? npm - pm : pm - npm;
        pm = npm;
        pmv = 1;
        if (npm < pmin) pmin = npm;
        if (npm > pmax) pmax = npm;
      end
      seen = 1;
      last_st = t + sk;
    end
    t += p;
    if (dk < p) begin
      rd(0, v);
      chk("R2 compute time", v, dk);
      rd(1, v);
      chk("R3 slack", v, p - dk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    #0.5;
    chk("R11 trig idle", int'(trig_o), 0);
    chk("R11 overrun", int'(overrun_o), 0);
    chk("R11 drop", int'(drop_o), 0);
    rd(0, v);  chk("R11 comp", v, 0);
    rd(2, v);  chk("R11 load", v, 0);
    rd(9, v);  chk("R11 miss count", v, 0);
    rd(5, v);  chk("R11 period min", v, ONES);
    rd(7, v);  chk("R11 compute min", v, ONES);
    @(negedge clk);
    enable_i = 1'b1;

    for (int i = 0; i < NV; i++)
      run_cycle(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);

    // totals at the negedge of the next trigger cycle
    rd(9, v);  chk("R5 miss count", v, miss);
    chk("R5 overrun flag", int'(overrun_o), 1);
    rd(10, v); chk("R6 spurious count", v, spur);
    rd(11, v); chk("R9 drop count", v, drop);
    chk("R9 drop flag", int'(drop_o), 1);
    enable_i = 1'b0;
    rd(3, v);  chk("R7 strobe period", v, pm);
    rd(4, v);  chk("R7 jitter", v, jit);
    rd(5, v);  chk("R8 period min", v, pmin);
    rd(6, v);  chk("R8 period max", v, pmax);
    rd(7, v);  chk("R8 compute min", v, cmin);
    rd(8, v);  chk("R8 compute max", v, cmax);

    repeat (5) @(negedge clk);
    chk("R5 overrun sticky while idle", int'(overrun_o), 1);
    chk("R9 drop sticky while idle", int'(drop_o), 1);

    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    #0.5;
    chk("R10 overrun cleared", int'(overrun_o), 0);
    chk("R10 drop cleared", int'(drop_o), 0);
    rd(9, v);  chk("R10 miss count", v, 0);
    rd(10, v); chk("R10 spurious count", v, 0);
    rd(11, v); chk("R10 drop count", v, 0);
    rd(5, v);  chk("R10 period min", v, ONES);
    rd(6, v);  chk("R10 period max", v, 0);
    rd(7, v);  chk("R10 compute min", v, ONES);
    rd(8, v);  chk("R10 compute max", v, 0);

    // stray done with nothing open
    @(negedge clk);
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    @(negedge clk);
    rd(10, v); chk("R6 stray done counted", v, 1);
    rd(0, v);  chk("R6 compute unchanged", v, last_comp);
    rd(1, v);  chk("R6 slack unchanged", v, VEC[NV-1][0] - last_comp);
    rd(7, v);  chk("R6 compute min unchanged", v, ONES);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule